// File: doc/BRIEF.md
# Keyboard Beep Tone Generator

This block makes the square wave that drives a keyboard beeper. A free-running counter advances once every two system clocks. The tone is taken from one bit of that counter. Software picks the bit by writing a one-hot pattern into a tap register, and turns the tone on with an enable register.

The system clock can be slowed to save power. When that happens, the block moves to a lower counter bit by itself, so the pitch that reaches the speaker does not change. The current clock mode arrives on a two-bit input. The tone output is registered, and it follows a change in register, counter or mode one clock later.

Top module: `beep_tone_gen`

## Requirements
- R1: While reset is high, and in the cycle after it falls, tone_out is 0. Reset clears the enable register, the tap register and the counter.
- R2: The counter advances by one every second system clock. With tap bit 10 selected in full-speed mode, tone_out has a period of 4096 system clocks.
- R3: Word address 1 holds the tap register. Data bits 18 down to 10 select counter bits 18 down to 10, one-hot. All other data bits are ignored.
- R4: Word address 0 holds the enable register. Data bit 0 turns the tone on and all other data bits are ignored.
- R5: With the enable clear, tone_out is 0 but the counter keeps running. After the enable is set again, the tone resumes in the phase of the uninterrupted counter.
- R6: If the tap field holds no set bit, or more than one set bit, tone_out is 0.
- R7: When freq_mode is 1 (half speed), the effective tap is one bit below the programmed one.
- R8: When freq_mode is 2 (one-thirty-second speed), the effective tap is five bits below the programmed one, clamped at bit 0. freq_mode 0 and 3 both mean full speed.
- R9: A write to any word address other than 0 or 1 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address |
| wr_data | input | 32 | Register write data |
| freq_mode | input | 2 | Clock mode: 0 full, 1 half, 2 one-thirty-second, 3 full |
| tone_out | output | 1 | Registered square-wave tone |

## Verification
Some properties are checked on every cycle. The counter steps only on alternate clocks and wraps cleanly. The output stays low whenever the enable is clear or the tap pattern is not one-hot. A write to the enable register lands one cycle later, and a write to an unmapped address leaves both registers unchanged. Other behaviour can only be shown by the bench's scenarios, which compare the output on every cycle against a model and measure tone periods. These are the tap remapping in the slow clock modes, the masking of reserved data bits, and the counter phase surviving a spell with the tone disabled.

// File: rtl/beep_pkg.sv
package beep_pkg;

  typedef enum logic [1:0] {
    FM_FULL = 2'd0,
    FM_HALF = 2'd1,
    FM_SLOW = 2'd2,
    FM_RSVD = 2'd3
  } freq_mode_e;

  // Bits the effective tap drops below the programmed one in each mode.
  localparam int HALF_DROP = 1;
  localparam int SLOW_DROP = 5;

endpackage

// File: rtl/beep_regs.sv
module beep_regs #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int TAP_LO   = 10,
  parameter int TAP_N    = 9,
  parameter int ADDR_EN  = 0,
  parameter int ADDR_TAP = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              en_q,
  output logic [TAP_N-1:0]  tap_q
);

  localparam int TAP_HI = TAP_LO + TAP_N - 1;

  logic hit_en, hit_tap;
  assign hit_en  = wr_en && (wr_addr == ADDR_W'(ADDR_EN));
  assign hit_tap = wr_en && (wr_addr == ADDR_W'(ADDR_TAP));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      tap_q <= '0;
    end else begin
      if (hit_en)  en_q  <= wr_data[0];
      if (hit_tap) tap_q <= wr_data[TAP_HI:TAP_LO];
    end
  end

  a_r4_enable_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(ADDR_EN)) |=> (en_q == $past(wr_data[0])));

  a_r9_unmapped_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != ADDR_W'(ADDR_EN) && wr_addr != ADDR_W'(ADDR_TAP))
      |=> ($stable(en_q) && $stable(tap_q)));

endmodule

// File: rtl/beep_counter.sv
module beep_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_q
);

  // The phase flag halves the system rate.
  logic ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      ph_q <= ~ph_q;
      if (ph_q) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  a_r2_holds_on_even: assert property (@(posedge clk) disable iff (rst)
    !ph_q |=> $stable(cnt_q));

  a_r2_steps_on_odd: assert property (@(posedge clk) disable iff (rst)
    ph_q |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/beep_tap_sel.sv
module beep_tap_sel #(
  parameter int TAP_LO = 10,
  parameter int TAP_N  = 9,
  parameter int IDX_W  = 5
) (
  input  logic [TAP_N-1:0] tap,
  input  logic [1:0]       mode,
  output logic [IDX_W-1:0] eff_idx,
  output logic             tap_ok
);
  import beep_pkg::*;

  // Each set tap bit contributes the counter index it stands for.
  logic [IDX_W-1:0] bit_idx [TAP_N];

  for (genvar g = 0; g < TAP_N; g++) begin : g_tap
    assign bit_idx[g] = tap[g] ? IDX_W'(TAP_LO + g) : '0;
  end

  assign tap_ok = (tap != '0) && ((tap & (tap - TAP_N'(1))) == '0);

  int prog, drop;

  always_comb begin
    prog = 0;
    for (int i = 0; i < TAP_N; i++) prog = prog | int'(bit_idx[i]);
    unique case (freq_mode_e'(mode))
      FM_HALF: drop = HALF_DROP;
      FM_SLOW: drop = SLOW_DROP;
      default: drop = 0;
    endcase
    // Clamp at bit 0 for narrow tap windows.
    eff_idx = (prog < drop) ? '0 : IDX_W'(prog - drop);
  end

endmodule

// File: rtl/beep_tone_gen.sv
module beep_tone_gen #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 20,
  parameter int TAP_LO   = 10,
  parameter int TAP_N    = 9,
  parameter int ADDR_EN  = 0,
  parameter int ADDR_TAP = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        freq_mode,
  output logic              tone_out
);

  localparam int IDX_W = $clog2(CNT_W);

  logic             en_q;
  logic [TAP_N-1:0] tap_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] eff_idx;
  logic             tap_ok;

  beep_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAP_LO(TAP_LO), .TAP_N(TAP_N),
    .ADDR_EN(ADDR_EN), .ADDR_TAP(ADDR_TAP)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .en_q(en_q), .tap_q(tap_q)
  );

  beep_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt_q(cnt_q)
  );

  beep_tap_sel #(.TAP_LO(TAP_LO), .TAP_N(TAP_N), .IDX_W(IDX_W)) u_sel (
    .tap(tap_q), .mode(freq_mode), .eff_idx(eff_idx), .tap_ok(tap_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) tone_out <= 1'b0;
    else     tone_out <= en_q && tap_ok && cnt_q[eff_idx];
  end

  a_r5_disabled_low: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !tone_out);

  a_r6_bad_tap_low: assert property (@(posedge clk) disable iff (rst)
    !tap_ok |=> !tone_out);

endmodule

// File: tb/test_beep_tone_gen.sv
module test_beep_tone_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  freq_mode = 2'd0;
  logic        tone_out;

  int    n_run = 0;
  int    n_fail = 0;
  string tag = "R1";
  bit    done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  beep_tone_gen i_beep_tone_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .freq_mode(freq_mode), .tone_out(tone_out)
  );

  // Reference model, stepped on each rising edge, pushes the expected output.
  int   m_cnt = 0;
  bit   m_ph = 0;
  bit   m_en = 0;
  int   m_tap = 0;
  logic exp_q [$];

  function automatic bit model_tone(int cnt, bit en, int tap, logic [1:0] md);
    int ones = 0, pos = 0, drop, eff;
    for (int i = 0; i < 9; i++) if (tap[i]) begin ones++; pos = 10 + i; end
    if (!en || ones != 1) return 1'b0;
    drop = (md == 2'd1) ? 1 : (md == 2'd2) ? 5 : 0;
    eff = (pos < drop) ? 0 : pos - drop;
    return cnt[eff];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      exp_q.push_back(1'b0);
      m_cnt = 0; m_ph = 0; m_en = 0; m_tap = 0;
    end else begin
      exp_q.push_back(model_tone(m_cnt, m_en, m_tap, freq_mode));
      if (wr_en && wr_addr == 4'd0) m_en = wr_data[0];
      if (wr_en && wr_addr == 4'd1) m_tap = int'(wr_data[18:10]);
      if (m_ph) m_cnt = (m_cnt + 1) & 32'h000F_FFFF;
      m_ph = ~m_ph;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor: one comparison per cycle, away from the edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic e;
      e = exp_q.pop_front();
      chk(tone_out === e, tag, int'(tone_out), int'(e));
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic period(int exp, string req);
    logic p;
    int   n = 0;
    do begin p = tone_out; @(negedge clk); end while (!(tone_out && !p));
    do begin p = tone_out; @(negedge clk); n++; end while (!(tone_out && !p));
    chk(n == exp, req, n, exp);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    idle(2);
    chk(tone_out == 1'b0, "R1", int'(tone_out), 0);
    idle(3);
    rst = 1'b0;
    idle(20);

    tag = "R4";
    wr(0, 32'h1);
    tag = "R3";
    wr(1, 32'h0000_0400);
    tag = "R2";
    idle(5000);
    period(4096, "R2");

    tag = "R3";
    wr(1, 32'hFFF8_03FF | 32'h0000_1000);
    period(16384, "R3");

    tag = "R5";
    wr(1, 32'h0000_0400);
    wr(0, 32'hFFFF_FFFE);
    idle(6000);
    wr(0, 32'h1);
    idle(5000);

    tag = "R6";
    wr(1, 32'h0);
    idle(3000);
    wr(1, 32'h0000_0C00);
    idle(3000);

    tag = "R7";
    wr(1, 32'h0000_0800);
    freq_mode = 2'd1;
    period(4096, "R7");
    idle(2000);

    tag = "R8";
    wr(1, 32'h0000_8000);
    freq_mode = 2'd2;
    period(4096, "R8");
    wr(1, 32'h0000_0400);
    freq_mode = 2'd3;
    period(4096, "R8");

    tag = "R9";
    freq_mode = 2'd0;
    wr(5, 32'h0);
    wr(9, 32'h0000_0000);
    idle(3000);
    period(4096, "R9");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule